// File: doc/BRIEF.md
# Oscillator Auto-Trim Controller

This block calibrates the trim code of an on-chip RC oscillator by comparing it with a faster, accurate reference clock. It searches one trim bit at a time. Software chooses which of two oscillators to calibrate and loads a 16-bit target count. It then pulses the enable write, and the controller runs a successive-approximation search over the trim code.

For each bit, the bit under test is set to 1. The controller then measures one full period of the selected oscillator, counted in reference-clock cycles. A count above the target means the oscillator is still too slow, so the bit is kept; otherwise the bit is cleared. The fast oscillator is divided by 128 before the measurement. This brings it into the same period range as the slow one.

Both oscillators enter the reference domain through two-flop synchronisers, and their rising edges are detected there. No logic is clocked by an oscillator. The calibration is cancelled in two cases: a write to any guarded control register, or a stop-mode request. A cancelled calibration raises a sticky fail flag.

Top module: `osc_autotrim`

## Requirements
- R1: After reset, `busy_o` is 0, `fail_o` is 0 and `trim_o` is 0.
- R2: When the block is idle, an `enable_wr_i` pulse with `guard_wr_i` and `stop_i` both low starts a search. In the next cycle `busy_o` is 1, `fail_o` is 0 and `trim_o` holds only its most significant bit (9'h100 by default). `target_i` and `sel_fast_i` are sampled in that same cycle.
- R3: Bits are decided strictly from the most significant to the least significant. Between consecutive cycles of a search, at most two trim bits change. `busy_o` stays 1 until bit 0 is decided, then drops, and `trim_o` holds the final code.
- R4: Each bit's count is the number of reference cycles between two consecutive rising edges of the selected (divided) oscillator, and this period is measured with the tentative code applied. The tested bit stays 1 only if the count is strictly greater than the target. A count equal to the target clears it.
- R5: With `sel_fast_i` = 0, the slow oscillator is measured directly. With `sel_fast_i` = 1, the window spans 128 fast-oscillator periods. Changing `sel_fast_i` during a search has no effect.
- R6: A `guard_wr_i` pulse while busy ends the search in the next cycle: `busy_o` is 0, `fail_o` is 1, and `trim_o` keeps the value it had when the search was cancelled.
- R7: A `stop_i` pulse while busy cancels the search in the same way as R6.
- R8: `fail_o` stays set until `fail_clr_i` is pulsed or a new search is accepted. Either of these clears it in the next cycle.
- R9: An `enable_wr_i` pulse while busy, with no guarded write or stop request present, restarts the search from the most significant bit.
- R10: While idle, `guard_wr_i` and `stop_i` change nothing. An `enable_wr_i` pulse that arrives together with `stop_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| osc_slow_i | input | 1 | Slow RC oscillator output (asynchronous) |
| osc_fast_i | input | 1 | Fast RC oscillator output (asynchronous) |
| sel_fast_i | input | 1 | Oscillator choice: 0 slow, 1 fast divided by 128 |
| target_i | input | 16 | Target period count in reference cycles |
| enable_wr_i | input | 1 | One-cycle pulse: write 1 to the enable bit |
| guard_wr_i | input | 1 | One-cycle pulse: a guarded control register was written |
| stop_i | input | 1 | Stop-mode entry request |
| fail_clr_i | input | 1 | One-cycle pulse: write 1 to clear the fail flag |
| busy_o | output | 1 | Enable bit readback; 1 while a search runs |
| fail_o | output | 1 | Sticky cancellation flag |
| trim_o | output | 9 | Trim code driving the oscillator |

## Verification
The bench drives behavioural oscillators whose period depends on `trim_o`, so a correct search converges to a code the bench can predict. One target is chosen so that an intermediate count equals it exactly. A design that keeps the bit on equality, or that counts one cycle too many or too few, would therefore settle on a different code. Further cases include a cancellation mid-search that must freeze the partial code, a restart after the first decision, and a change of `sel_fast_i` after the start. A design that reads the select bit live would mix the two sources and miss the expected code. Idle pulses of the cancel inputs must leave the fail flag clear, and an enable that coincides with a stop request must not start a search.

// File: rtl/autotrim_pkg.sv
`timescale 1ns/1ps
package autotrim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_ARM    = 2'd2,
    ST_MEAS   = 2'd3
  } at_state_e;
endpackage

// File: rtl/at_edge_sync.sv
`timescale 1ns/1ps
module at_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[LAST];
      rise_o <= sync_q[LAST] & ~last_q;
    end
  end
endmodule

// File: rtl/at_prescale.sv
`timescale 1ns/1ps
module at_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  generate
    if (DIV <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) tick_o <= 1'b0;
        else     tick_o <= edge_i;
      end
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q  <= '0;
          tick_o <= 1'b0;
        end else begin
          tick_o <= 1'b0;
          if (edge_i) begin
            if (cnt_q == TOP) begin
              cnt_q  <= '0;
              tick_o <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/at_gate_counter.sv
`timescale 1ns/1ps
module at_gate_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_o <= '0;
    else if (load_i)              cnt_o <= ONE;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + ONE;
  end
endmodule

// File: rtl/at_sar_ctrl.sv
`timescale 1ns/1ps
module at_sar_ctrl
  import autotrim_pkg::*;
#(
  parameter int TRIM_W          = 9,
  parameter int CNT_W           = 16,
  parameter bit KEEP_ON_GREATER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cancel_i,
  input  logic              fail_clr_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  target_i,
  output logic              busy_o,
  output logic              fail_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              cnt_load_o,
  output logic              cnt_inc_o,
  output logic              accept_o
);
  localparam logic [TRIM_W-1:0] MSB = {1'b1, {(TRIM_W-1){1'b0}}};

  at_state_e         state_q;
  logic [TRIM_W-1:0] mask_q;
  logic [CNT_W-1:0]  target_q;
  logic              keep;
  logic              cancel_now;

  generate
    if (KEEP_ON_GREATER) begin : g_gt
      assign keep = count_i > target_q;
    end else begin : g_lt
      assign keep = count_i < target_q;
    end
  endgenerate

  always_comb begin
    accept_o   = start_i && !cancel_i;
    cancel_now = busy_o && cancel_i;
    cnt_load_o = (state_q == ST_ARM) && tick_i && !cancel_now && !accept_o;
    cnt_inc_o  = (state_q == ST_MEAS) && !tick_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      busy_o   <= 1'b0;
      fail_o   <= 1'b0;
      trim_o   <= '0;
      mask_q   <= '0;
      target_q <= '0;
    end else begin
      if (fail_clr_i) fail_o <= 1'b0;
      if (cancel_now) begin
        state_q <= ST_IDLE;
        busy_o  <= 1'b0;
        fail_o  <= 1'b1;
      end else if (accept_o) begin
        state_q  <= ST_SETTLE;
        busy_o   <= 1'b1;
        fail_o   <= 1'b0;
        trim_o   <= MSB;
        mask_q   <= MSB;
        target_q <= target_i;
      end else begin
        case (state_q)
          ST_SETTLE: if (tick_i) state_q <= ST_ARM;
          ST_ARM:    if (tick_i) state_q <= ST_MEAS;
          ST_MEAS: begin
            if (tick_i) begin
              trim_o <= (trim_o & ~mask_q) | (keep ? mask_q : '0) | (mask_q >> 1);
              mask_q <= mask_q >> 1;
              if (mask_q[0]) begin
                state_q <= ST_IDLE;
                busy_o  <= 1'b0;
              end else begin
                state_q <= ST_ARM;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/osc_autotrim.sv
`timescale 1ns/1ps
module osc_autotrim #(
  parameter int TRIM_W          = 9,
  parameter int CNT_W           = 16,
  parameter int FAST_DIV        = 128,
  parameter int SYNC_STAGES     = 2,
  parameter bit KEEP_ON_GREATER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_slow_i,
  input  logic              osc_fast_i,
  input  logic              sel_fast_i,
  input  logic [CNT_W-1:0]  target_i,
  input  logic              enable_wr_i,
  input  logic              guard_wr_i,
  input  logic              stop_i,
  input  logic              fail_clr_i,
  output logic              busy_o,
  output logic              fail_o,
  output logic [TRIM_W-1:0] trim_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0]  osc_vec;
  logic [NSRC-1:0]  rise_vec;
  logic             fast_tick;
  logic             sel_q;
  logic             tick;
  logic             accept;
  logic             cnt_load;
  logic             cnt_inc;
  logic [CNT_W-1:0] count;

  assign osc_vec = {osc_fast_i, osc_slow_i};

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_sync
      at_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (osc_vec[g]),
        .rise_o  (rise_vec[g])
      );
    end
  endgenerate

  at_prescale #(.DIV(FAST_DIV)) u_prescale (
    .clk    (clk),
    .rst    (rst),
    .edge_i (rise_vec[1]),
    .tick_o (fast_tick)
  );

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 1'b0;
    else if (accept) sel_q <= sel_fast_i;
  end

  assign tick = sel_q ? fast_tick : rise_vec[0];

  at_gate_counter #(.W(CNT_W)) u_counter (
    .clk    (clk),
    .rst    (rst),
    .load_i (cnt_load),
    .inc_i  (cnt_inc),
    .cnt_o  (count)
  );

  at_sar_ctrl #(
    .TRIM_W          (TRIM_W),
    .CNT_W           (CNT_W),
    .KEEP_ON_GREATER (KEEP_ON_GREATER)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (enable_wr_i),
    .cancel_i   (guard_wr_i | stop_i),
    .fail_clr_i (fail_clr_i),
    .tick_i     (tick),
    .count_i    (count),
    .target_i   (target_i),
    .busy_o     (busy_o),
    .fail_o     (fail_o),
    .trim_o     (trim_o),
    .cnt_load_o (cnt_load),
    .cnt_inc_o  (cnt_inc),
    .accept_o   (accept)
  );
endmodule

// File: rtl/at_checker.sv
`timescale 1ns/1ps
module at_checker #(
  parameter int TRIM_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              enable_wr_i,
  input logic              guard_wr_i,
  input logic              stop_i,
  input logic              fail_clr_i,
  input logic              busy_o,
  input logic              fail_o,
  input logic [TRIM_W-1:0] trim_o
);
  localparam logic [TRIM_W-1:0] MSB = {1'b1, {(TRIM_W-1){1'b0}}};

  logic cancel;
  assign cancel = guard_wr_i | stop_i;

  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && enable_wr_i && !cancel) |=> (busy_o && !fail_o && trim_o == MSB));

  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    (busy_o && enable_wr_i && !cancel) |=> (busy_o && trim_o == MSB));

  a_r6_guard_abort: assert property (@(posedge clk) disable iff (rst)
    (busy_o && guard_wr_i) |=> (!busy_o && fail_o && $stable(trim_o)));

  a_r7_stop_abort: assert property (@(posedge clk) disable iff (rst)
    (busy_o && stop_i) |=> (!busy_o && fail_o && $stable(trim_o)));

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !fail_clr_i && !(enable_wr_i && !cancel)) |=> fail_o);

  a_r8_fail_clear: assert property (@(posedge clk) disable iff (rst)
    (fail_o && fail_clr_i && !(busy_o && cancel)) |=> !fail_o);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !(enable_wr_i && !cancel)) |=> (!busy_o && $stable(trim_o)));

  a_r10_idle_fail: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !enable_wr_i && !fail_clr_i) |=> $stable(fail_o));

  a_r3_one_step: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !enable_wr_i && !cancel) |=> ($countones(trim_o ^ $past(trim_o)) <= 2));
endmodule

bind osc_autotrim at_checker #(.TRIM_W(TRIM_W)) u_at_checker (
  .clk         (clk),
  .rst         (rst),
  .enable_wr_i (enable_wr_i),
  .guard_wr_i  (guard_wr_i),
  .stop_i      (stop_i),
  .fail_clr_i  (fail_clr_i),
  .busy_o      (busy_o),
  .fail_o      (fail_o),
  .trim_o      (trim_o)
);

// File: tb/test_osc_autotrim.sv
`timescale 1ns/1ps
module test_osc_autotrim;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        osc_slow = 1'b0;
  logic        osc_fast = 1'b0;
  logic        sel_fast = 1'b0;
  logic [15:0] target = '0;
  logic        enable_wr = 1'b0;
  logic        guard_wr = 1'b0;
  logic        stop_req = 1'b0;
  logic        fail_clr = 1'b0;
  logic        busy;
  logic        fail;
  logic [8:0]  trim;

  int checks = 0;
  int errs   = 0;

  osc_autotrim i_osc_autotrim (
    .clk         (clk),
    .rst         (rst),
    .osc_slow_i  (osc_slow),
    .osc_fast_i  (osc_fast),
    .sel_fast_i  (sel_fast),
    .target_i    (target),
    .enable_wr_i (enable_wr),
    .guard_wr_i  (guard_wr),
    .stop_i      (stop_req),
    .fail_clr_i  (fail_clr),
    .busy_o      (busy),
    .fail_o      (fail),
    .trim_o      (trim)
  );

  always #4 clk = ~clk;

  // Oscillator models: period in reference cycles, taken at each rising edge.
  function automatic int slow_period(input int t);
    return 600 - t;
  endfunction

  function automatic int fast_period(input int t);
    return 12 - t / 128;
  endfunction

  function automatic int window_count(input int sel, input int t);
    return (sel != 0) ? 128 * fast_period(t) : slow_period(t);
  endfunction

  function automatic int expect_code(input int sel, input int tgt);
    int t = 0;
    for (int b = 8; b >= 0; b--) begin
      t = t | (1 << b);
      if (!(window_count(sel, t) > tgt)) t = t & ~(1 << b);
    end
    return t;
  endfunction

  initial begin
    #103;
    forever begin
      int p;
      p = slow_period(int'(trim));
      osc_slow = 1'b1;
      #(p * 4);
      osc_slow = 1'b0;
      #(p * 4);
    end
  end

  initial begin
    #103;
    forever begin
      int q;
      q = fast_period(int'(trim));
      osc_fast = 1'b1;
      #(q * 4);
      osc_fast = 1'b0;
      #(q * 4);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_search(input logic sel, input int tgt);
    @(negedge clk);
    sel_fast  = sel;
    target    = 16'(tgt);
    enable_wr = 1'b1;
    @(negedge clk);
    enable_wr = 1'b0;
    check("R2 busy after start", int'(busy), 1);
    check("R2 trim after start", int'(trim), 256);
    check("R2 fail after start", int'(fail), 0);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 60000) begin
      @(negedge clk);
      n++;
    end
    check("R3 search completes", int'(busy), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy at reset", int'(busy), 0);
    check("R1 fail at reset", int'(fail), 0);
    check("R1 trim at reset", int'(trim), 0);
  endtask

  task automatic t_slow_equal();
    start_search(1'b0, 400);
    wait_idle();
    check("R4 slow code with equal count", int'(trim), expect_code(0, 400));
    check("R4 equal count clears bit", int'(trim), 199);
    check("R3 no fail after completion", int'(fail), 0);
  endtask

  task automatic t_slow_other();
    start_search(1'b0, 150);
    wait_idle();
    check("R3 slow code target 150", int'(trim), expect_code(0, 150));
  endtask

  task automatic t_fast();
    start_search(1'b1, 1300);
    sel_fast = 1'b0;
    wait_idle();
    check("R5 fast divided code", int'(trim), expect_code(1, 1300));
  endtask

  task automatic t_guard_abort();
    logic [8:0] snap;
    start_search(1'b0, 400);
    repeat (1500) @(negedge clk);
    snap = trim;
    guard_wr = 1'b1;
    @(negedge clk);
    guard_wr = 1'b0;
    check("R6 busy after guard write", int'(busy), 0);
    check("R6 fail after guard write", int'(fail), 1);
    check("R6 trim frozen", int'(trim), int'(snap));
    repeat (1000) @(negedge clk);
    check("R6 trim still frozen", int'(trim), int'(snap));
    check("R8 fail sticky", int'(fail), 1);
    fail_clr = 1'b1;
    @(negedge clk);
    fail_clr = 1'b0;
    check("R8 fail cleared by write", int'(fail), 0);
  endtask

  task automatic t_stop_abort();
    start_search(1'b0, 400);
    repeat (700) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check("R7 busy after stop", int'(busy), 0);
    check("R7 fail after stop", int'(fail), 1);
    start_search(1'b0, 400);
    check("R8 new enable clears fail", int'(fail), 0);
    wait_idle();
    check("R8 search after cancel", int'(trim), 199);
  endtask

  task automatic t_restart();
    int n = 0;
    start_search(1'b0, 400);
    while (trim == 9'h100 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check("R4 first decision clears msb", int'(trim), 128);
    @(negedge clk);
    enable_wr = 1'b1;
    @(negedge clk);
    enable_wr = 1'b0;
    check("R9 restart trim", int'(trim), 256);
    check("R9 restart busy", int'(busy), 1);
    wait_idle();
    check("R9 restart result", int'(trim), 199);
  endtask

  task automatic t_idle_ignore();
    logic [8:0] snap;
    snap = trim;
    @(negedge clk);
    guard_wr = 1'b1;
    @(negedge clk);
    guard_wr = 1'b0;
    stop_req = 1'b1;
    @(negedge clk);
    check("R10 idle guard/stop busy", int'(busy), 0);
    check("R10 idle guard/stop fail", int'(fail), 0);
    enable_wr = 1'b1;
    @(negedge clk);
    enable_wr = 1'b0;
    stop_req  = 1'b0;
    check("R10 enable with stop ignored", int'(busy), 0);
    repeat (3) @(negedge clk);
    check("R10 idle trim unchanged", int'(trim), int'(snap));
    check("R10 idle fail unchanged", int'(fail), 0);
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_slow_equal();
    t_idle_ignore();
    t_slow_other();
    t_fast();
    t_guard_abort();
    t_stop_abort();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule